// File: doc/BRIEF.md
# Configuration and Object Allocation Tracker

This block follows the life cycle of one reconfigurable configuration and of the fixed set of hardware objects that live inside it. Each of these items sits in one of three states: not loaded, available, or in use. Load and unload requests move the whole configuration. Allocate and release requests move a single object, which is selected by an index. The configuration state follows its objects. The first allocation marks the configuration as in use. The release of the last object in use marks it available again.

The block answers every request in the cycle after it arrives, with either a one-cycle grant pulse or a one-cycle error pulse. A request that breaks a rule changes no state. The main rule is that a configuration with any object in use cannot be unloaded. The block does not do the bitstream transfer, and it does not decide which object a client receives. Both are left to the logic around it.

Top module: `cfg_obj_tracker`

## Requirements
- R1: After reset, the configuration state and every object state read 0 (not loaded), and grant and error are low. The state codes are 0 = not loaded, 1 = available, 2 = in use. Object k occupies bits [2k+1:2k] of the object state vector.
- R2: A load request while the configuration is not loaded sets the configuration and every object to 1. Grant pulses high in the next cycle.
- R3: An allocate request on an object in state 1 moves that object to 2 and the configuration to 2. Grant pulses high in the next cycle.
- R4: A release request on an object in state 2 moves that object to 1. The configuration stays at 2 while any other object is still in use, and returns to 1 when the last object in use is released.
- R5: An unload request while the configuration is in state 2 gives an error pulse and leaves every state unchanged.
- R6: An unload request while the configuration is in state 1 returns the configuration and all objects to 0 in one cycle, with a grant pulse.
- R7: An allocate request on an object that is not in state 1, or with an index of N_OBJ or higher, gives an error pulse and changes no state.
- R8: A release request on an object that is not in state 2, or with an index of N_OBJ or higher, gives an error pulse and changes no state.
- R9: A load request while the configuration is loaded, or an unload request while it is not loaded, gives an error pulse and changes no state.
- R10: If more than one of the four request inputs is high in the same cycle, the block gives an error pulse and changes no state.
- R11: While the configuration remains loaded, a released object can be allocated again.
- R12: Grant and error are never high together. Exactly one of them pulses in the cycle after a request, and neither pulses after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_req | input | 1 | Request to load the configuration |
| unload_req | input | 1 | Request to unload the configuration |
| alloc_req | input | 1 | Request to allocate the object at obj_idx |
| rel_req | input | 1 | Request to release the object at obj_idx |
| obj_idx | input | IDX_W | Object index for allocate and release requests |
| cfg_state_o | output | 2 | Configuration state code |
| obj_state_o | output | 2*N_OBJ | Packed object state codes, two bits per object |
| grant_o | output | 1 | One-cycle pulse: the previous request was accepted |
| error_o | output | 1 | One-cycle pulse: the previous request was refused |

## Verification
The bench builds the block with N_OBJ = 5 and IDX_W = 3. Because five is not a power of two, indices 5 to 7 can be driven on the index port, which exercises the out-of-range refusals. Five objects also allow several objects to be in use at once, so the bench can release them in an order where the configuration stays in use until the final release. Random request mixes, including some cycles with more than one request high, then push the allocation count through its full range many times.

// File: rtl/cfgtrk_pkg.sv
package cfgtrk_pkg;

  typedef enum logic [1:0] {
    LS_UNLOADED = 2'd0,
    LS_AVAIL    = 2'd1,
    LS_INUSE    = 2'd2
  } life_t;

  // Next value of the in-use count
  function automatic int step_count(int cur, logic inc, logic dec);
    if (inc && !dec) return cur + 1;
    if (dec && !inc) return cur - 1;
    return cur;
  endfunction

  // A release empties the configuration when exactly one object is in use
  function automatic logic is_last_user(int cur);
    return cur == 1;
  endfunction

endpackage

// File: rtl/cfgtrk_slot.sv
module cfgtrk_slot
  import cfgtrk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_all,
  input  logic  clear_all,
  input  logic  set_use,
  input  logic  clr_use,
  output life_t state_o
);

  life_t st_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         st_q <= LS_UNLOADED;
    else if (clear_all) st_q <= LS_UNLOADED;
    else if (load_all)  st_q <= LS_AVAIL;
    else if (set_use)   st_q <= LS_INUSE;
    else if (clr_use)   st_q <= LS_AVAIL;
  end

  assign state_o = st_q;

  p_slot_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_all && !clear_all) |=> (st_q == LS_AVAIL));

  p_slot_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (st_q == LS_UNLOADED));

  p_slot_use_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_use |-> (st_q == LS_AVAIL));

  p_slot_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_use |-> (st_q == LS_INUSE));

endmodule

// File: rtl/cfgtrk_counter.sv
module cfgtrk_counter
  import cfgtrk_pkg::*;
#(
  parameter int N_OBJ = 4,
  localparam int CW = $clog2(N_OBJ + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] count_o,
  output logic          last_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= CW'(step_count(int'(cnt_q), inc, dec));
  end

  assign count_o = cnt_q;
  assign last_o  = is_last_user(int'(cnt_q));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> (int'(cnt_q) < N_OBJ));

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (cnt_q != '0));

endmodule

// File: rtl/cfg_obj_tracker.sv
module cfg_obj_tracker
  import cfgtrk_pkg::*;
#(
  parameter int N_OBJ = 4,
  parameter int IDX_W = $clog2(N_OBJ + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_req,
  input  logic               unload_req,
  input  logic               alloc_req,
  input  logic               rel_req,
  input  logic [IDX_W-1:0]   obj_idx,
  output logic [1:0]         cfg_state_o,
  output logic [2*N_OBJ-1:0] obj_state_o,
  output logic               grant_o,
  output logic               error_o
);

  localparam int CW = $clog2(N_OBJ + 1);

  life_t         cfg_q;
  life_t         slot_st [N_OBJ];
  life_t         sel_state;
  logic [CW-1:0] use_cnt;
  logic          last_user;
  logic [3:0]    req_vec;
  logic          multi_req, any_req, idx_ok;
  logic          ev_load, ev_unload, ev_alloc, ev_rel, ev_ok, ev_bad;
  logic          grant_q, err_q;

  assign req_vec   = {load_req, unload_req, alloc_req, rel_req};
  assign multi_req = $countones(req_vec) > 1;
  assign any_req   = |req_vec;
  assign idx_ok    = int'(obj_idx) < N_OBJ;

  always_comb begin
    sel_state = LS_UNLOADED;
    for (int i = 0; i < N_OBJ; i++)
      if (obj_idx == IDX_W'(i)) sel_state = slot_st[i];
  end

  // Named accept events, one per request kind
  assign ev_load   = !multi_req && load_req   && (cfg_q == LS_UNLOADED);
  assign ev_unload = !multi_req && unload_req && (cfg_q == LS_AVAIL);
  assign ev_alloc  = !multi_req && alloc_req  && idx_ok && (sel_state == LS_AVAIL);
  assign ev_rel    = !multi_req && rel_req    && idx_ok && (sel_state == LS_INUSE);
  assign ev_ok     = ev_load | ev_unload | ev_alloc | ev_rel;
  assign ev_bad    = any_req && !ev_ok;

  genvar g;
  generate
    for (g = 0; g < N_OBJ; g++) begin : g_slot
      cfgtrk_slot u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_all (ev_load),
        .clear_all(ev_unload),
        .set_use  (ev_alloc && (obj_idx == IDX_W'(g))),
        .clr_use  (ev_rel   && (obj_idx == IDX_W'(g))),
        .state_o  (slot_st[g])
      );
      assign obj_state_o[2*g +: 2] = slot_st[g];
    end
  endgenerate

  cfgtrk_counter #(.N_OBJ(N_OBJ)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (ev_alloc),
    .dec    (ev_rel),
    .count_o(use_cnt),
    .last_o (last_user)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= LS_UNLOADED;
      grant_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (ev_load)                    cfg_q <= LS_AVAIL;
      else if (ev_unload)             cfg_q <= LS_UNLOADED;
      else if (ev_alloc)              cfg_q <= LS_INUSE;
      else if (ev_rel && last_user)   cfg_q <= LS_AVAIL;
      grant_q <= ev_ok;
      err_q   <= ev_bad;
    end
  end

  assign cfg_state_o = cfg_q;
  assign grant_o     = grant_q;
  assign error_o     = err_q;

  p_inuse_matches_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q == LS_INUSE) == (use_cnt != '0));

  p_unload_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (unload_req && cfg_q == LS_INUSE) |=> (err_q && cfg_q == LS_INUSE));

  p_multi_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    multi_req |=> (err_q && $stable(cfg_q)));

  p_resp_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_q && err_q));

  p_no_resp_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !any_req |=> (!grant_q && !err_q));

  p_unloaded_objs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q == LS_UNLOADED) |-> (obj_state_o == '0));

endmodule

// File: tb/cfg_obj_tracker_tb_top.sv
module cfg_obj_tracker_tb_top;

  localparam int N  = 5;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_req = 1'b0, unload_req = 1'b0, alloc_req = 1'b0, rel_req = 1'b0;
  logic [IW-1:0] obj_idx = '0;
  logic [1:0]    cfg_state_o;
  logic [2*N-1:0] obj_state_o;
  logic          grant_o, error_o;

  int compared = 0;
  int mismatched = 0;
  int exp_cfg;
  int exp_obj [N];

  always #10 clk = ~clk;

  cfg_obj_tracker #(.N_OBJ(N), .IDX_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .load_req(load_req), .unload_req(unload_req),
    .alloc_req(alloc_req), .rel_req(rel_req), .obj_idx(obj_idx),
    .cfg_state_o(cfg_state_o), .obj_state_o(obj_state_o),
    .grant_o(grant_o), .error_o(error_o)
  );

  function automatic logic [2*N-1:0] pack_obj();
    logic [2*N-1:0] v = '0;
    for (int k = 0; k < N; k++) v[2*k +: 2] = 2'(exp_obj[k]);
    return v;
  endfunction

  function automatic int users();
    int u = 0;
    for (int k = 0; k < N; k++) if (exp_obj[k] == 2) u++;
    return u;
  endfunction

  task automatic compare(string tag, logic eg, logic ee);
    compared++;
    if (cfg_state_o !== 2'(exp_cfg) || obj_state_o !== pack_obj() ||
        grant_o !== eg || error_o !== ee) begin
      mismatched++;
      $display("FAIL %s: got cfg=%0d obj=%h g=%b e=%b exp cfg=%0d obj=%h g=%b e=%b",
               tag, cfg_state_o, obj_state_o, grant_o, error_o,
               exp_cfg, pack_obj(), eg, ee);
    end
  endtask

  // Apply one request cycle, update the model, check the response
  task automatic op(logic ld, logic ul, logic al, logic rl, int idx, string tag);
    int n;
    logic ok;
    n  = int'(ld) + int'(ul) + int'(al) + int'(rl);
    ok = 1'b0;
    if (n == 1) begin
      if (ld && exp_cfg == 0) begin
        ok = 1'b1; exp_cfg = 1;
        for (int k = 0; k < N; k++) exp_obj[k] = 1;
      end else if (ul && exp_cfg == 1) begin
        ok = 1'b1; exp_cfg = 0;
        for (int k = 0; k < N; k++) exp_obj[k] = 0;
      end else if (al && idx < N && exp_obj[idx] == 1) begin
        ok = 1'b1; exp_obj[idx] = 2; exp_cfg = 2;
      end else if (rl && idx < N && exp_obj[idx] == 2) begin
        ok = 1'b1; exp_obj[idx] = 1;
        if (users() == 0) exp_cfg = 1;
      end
    end
    @(negedge clk);
    load_req = ld; unload_req = ul; alloc_req = al; rel_req = rl;
    obj_idx = IW'(idx);
    @(negedge clk);
    load_req = 0; unload_req = 0; alloc_req = 0; rel_req = 0;
    compare(tag, ok, (n > 0) && !ok);
  endtask

  initial begin
    #4000000;
    mismatched++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    exp_cfg = 0;
    for (int k = 0; k < N; k++) exp_obj[k] = 0;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 reset", 1'b0, 1'b0);

    op(0,0,1,0, 0, "R7 alloc while unloaded");
    op(0,1,0,0, 0, "R9 unload while unloaded");
    op(1,0,0,0, 0, "R2 load");
    op(1,0,0,0, 0, "R9 load while loaded");
    op(0,0,1,0, 0, "R3 alloc obj0");
    op(0,0,1,0, 3, "R3 alloc obj3");
    op(0,0,1,0, 0, "R7 alloc in-use obj");
    op(0,0,1,0, 6, "R7 alloc out of range");
    op(0,1,0,0, 0, "R5 unload while in use");
    op(0,0,0,1, 3, "R4 release obj3 cfg stays");
    op(0,0,0,1, 3, "R8 release available obj");
    op(0,0,0,1, 7, "R8 release out of range");
    op(0,0,0,1, 0, "R4 last release");
    op(0,0,1,0, 0, "R11 realloc obj0");
    op(0,0,0,1, 0, "R11 release again");
    op(1,0,1,0, 1, "R10 load plus alloc");
    op(0,0,1,1, 1, "R10 alloc plus release");
    op(0,0,0,0, 0, "R12 idle");
    op(0,1,0,0, 0, "R6 unload");
    op(0,0,0,1, 0, "R8 release while unloaded");

    for (int t = 0; t < 600; t++) begin
      int sel, idx;
      logic ld, ul, al, rl;
      sel = int'($urandom_range(0, 19));
      idx = int'($urandom_range(0, 7));
      ld = sel == 0; ul = sel == 1;
      al = sel >= 2 && sel <= 9;
      rl = sel >= 10 && sel <= 16;
      if (sel == 17) begin al = 1; ul = 1; end
      if (sel == 18) begin ld = 1; rl = 1; end
      op(ld, ul, al, rl, idx, "R12 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule